// File: doc/BRIEF.md
# Preemptive priority interrupt controller

This block chooses which of sixteen interrupt sources a processor should service next, and it decides when a new request may suspend the handler that is running. Each source has an enable bit and a three-bit urgency level. Level 0 is the most urgent and level 7 the least. A request input sets that source's pending bit. The controller offers the most urgent enabled pending source to the processor. The processor accepts the offer with a one-cycle take strobe, and the controller then runs a fixed entry window before it announces the handler start.

The controller keeps a stack of running urgency levels, so handlers can nest. A new request is offered only when it is strictly more urgent than the level on top of the stack. When a handler signals its end, one of two things happens. If a waiting request beats the level underneath, the controller moves straight to that request (a chained start). Otherwise it pops the stack and reports a return to the suspended level. If a more urgent request turns up while an entry is in progress, it replaces the chosen source without restarting the window.

The control state machine has three states. IDLE means the stack is empty. ENTRY means an entry window is counting. RUN means at least one handler is active. The transitions are:
- take: IDLE to ENTRY, and RUN to ENTRY for a preemption.
- commit: ENTRY to RUN at the end of the window.
- chain: RUN to RUN when a handler ends and a waiting request is chained.
- return: RUN to RUN when a handler ends and a nested level remains below it.
- last-return: RUN to IDLE when a handler ends and the stack is left empty.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The register port decodes addresses as follows. Address 0 holds the enable bits, bit s for source s. Addresses 1 to 4 each hold four priority fields: source 4(a-1)+j uses bits [8j+7:8j+5] of address a. Address 5 reads back the pending bits and ignores writes. All other bits, and addresses 6 and 7, read as zero, and writes to them have no effect.
- R2: A source whose enable bit is clear is never offered. Its pending bit stays set.
- R3: Among enabled pending sources, the offer goes to the lowest priority value. When priority values are equal, the lower source number wins.
- R4: An offer (`svc_valid`) is made only when the chosen source's priority value is strictly below `run_prio`. `svc_preempt` is 1 when a handler is already running.
- R5: After the clock edge that samples a take, `hnd_start` pulses for one cycle, immediately after the 8th following edge. `hnd_chain` is 0 on this pulse.
- R6: During entry, a pending enabled request with a strictly lower priority value replaces the chosen source, and the window does not restart. A request of equal value does not replace it.
- R7: A request input sets its pending bit. The bit clears when that source's handler start is committed.
- R8: `run_prio` shows the top of an 8-deep level stack and reads 8 when the stack is empty. Each committed start pushes the started source's priority.
- R9: At handler end, if a pending enabled request has a value below the level beneath the top (8 if none), the next cycle shows `hnd_start` with `hnd_chain`=1. The top entry is replaced in place, and that request's pending bit clears.
- R10: Otherwise, a handler end pops the stack and pulses `hnd_return`, and `run_prio` shows the resumed level.
- R11: A handler end strobe has no effect while idle or during entry.
- R12: After reset the controller is idle with `run_prio`=8, and it shows no offer, no pulses, no enables and all priorities at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request inputs, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| svc_valid | output | 1 | A source is offered for service |
| svc_id | output | 4 | Offered source number |
| svc_preempt | output | 1 | The offer would suspend a running handler |
| svc_take | input | 1 | Processor accepts the offer |
| hnd_end | input | 1 | Running handler has finished |
| hnd_start | output | 1 | One-cycle pulse: a handler begins |
| hnd_id | output | 4 | Source of the handler that began |
| hnd_chain | output | 1 | The start came from a chain, not an entry |
| hnd_return | output | 1 | One-cycle pulse: return to a suspended level |
| run_prio | output | 4 | Current running level, 8 when idle |

## Verification
A corrupted level stack shows up on `run_prio` in the cycle after a handler end. It also shows up in which requests are offered or chained, because the comparison against the level beneath decides between a chain and a return. A wrong pending bit or arbitration result appears straight away as the wrong `svc_id` on the offer, or as a chained start naming the wrong source. A fault in the entry counter or in the late-arrival logic shifts `hnd_start` away from its eighth edge, or names the source that was first chosen in place of the more urgent one that arrived later.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_RUN   = 2'd2
    } ctrl_state_e;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 3,
    parameter int AW      = 3,
    parameter int DW      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    input  logic [NUM_SRC-1:0]        pend_in,
    output logic [NUM_SRC-1:0]        en_out,
    output logic [NUM_SRC*PRIO_W-1:0] prio_out
);
    localparam int SLOTS    = DW / 8;
    localparam int NUM_PREG = (NUM_SRC + SLOTS - 1) / SLOTS;
    localparam int A_PEND   = NUM_PREG + 1;
    localparam int FOFS     = 8 - PRIO_W;

    logic [NUM_SRC-1:0] en_q;
    logic [PRIO_W-1:0]  prio_q [NUM_SRC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && addr == AW'(0)) begin
            en_q <= wdata[NUM_SRC-1:0];
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
        localparam int RA  = g / SLOTS + 1;
        localparam int BIT = (g % SLOTS) * 8 + FOFS;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[g] <= '0;
            end else if (wr_en && addr == AW'(RA)) begin
                prio_q[g] <= wdata[BIT +: PRIO_W];
            end
        end
        assign prio_out[g*PRIO_W +: PRIO_W] = prio_q[g];
    end

    assign en_out = en_q;

    always_comb begin
        rdata = '0;
        if (addr == AW'(0)) begin
            rdata[NUM_SRC-1:0] = en_q;
        end else if (addr == AW'(A_PEND)) begin
            rdata[NUM_SRC-1:0] = pend_in;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (addr == AW'(s / SLOTS + 1)) begin
                    rdata[(s % SLOTS) * 8 + FOFS +: PRIO_W] = prio_q[s];
                end
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 3,
    localparam int IDW    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    output logic                      best_valid,
    output logic [IDW-1:0]            best_id,
    output logic [PRIO_W-1:0]         best_prio
);
    // Scan from the top index down; "<=" lets a lower index take a tie.
    always_comb begin
        best_valid = 1'b0;
        best_id    = '0;
        best_prio  = '1;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (req[s] && (!best_valid || prio[s*PRIO_W +: PRIO_W] <= best_prio)) begin
                best_valid = 1'b1;
                best_id    = IDW'(s);
                best_prio  = prio[s*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_prio_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int LVL_W    = 4,
    parameter int IDLE_LVL = 8,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int IW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    input  logic [LVL_W-1:0] lvl_in,
    output logic [LVL_W-1:0] top,
    output logic [LVL_W-1:0] below,
    output logic [CW-1:0]    depth
);
    logic [LVL_W-1:0] mem [DEPTH];
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    top_idx;
    logic [IW-1:0]    below_idx;
    logic [IW-1:0]    push_idx;

    assign top_idx   = IW'(cnt_q - CW'(1));
    assign below_idx = IW'(cnt_q - CW'(2));
    assign push_idx  = IW'(cnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                STK_PUSH: begin
                    if (cnt_q < CW'(DEPTH)) begin
                        mem[push_idx] <= lvl_in;
                        cnt_q         <= cnt_q + CW'(1);
                    end
                end
                STK_POP: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
                end
                STK_SWAP: begin
                    if (cnt_q != '0) mem[top_idx] <= lvl_in;
                end
                STK_HOLD: ;
            endcase
        end
    end

    assign top   = (cnt_q == '0)      ? LVL_W'(IDLE_LVL) : mem[top_idx];
    assign below = (cnt_q <= CW'(1))  ? LVL_W'(IDLE_LVL) : mem[below_idx];
    assign depth = cnt_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC      = 16,
    parameter int PRIO_W       = 3,
    parameter int STACK_DEPTH  = 8,
    parameter int ENTRY_CYCLES = 8,
    parameter int REG_AW       = 3,
    parameter int REG_DW       = 32,
    localparam int IDW         = $clog2(NUM_SRC),
    localparam int LVL_W       = PRIO_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    output logic               svc_valid,
    output logic [IDW-1:0]     svc_id,
    output logic               svc_preempt,
    input  logic               svc_take,
    input  logic               hnd_end,
    output logic               hnd_start,
    output logic [IDW-1:0]     hnd_id,
    output logic               hnd_chain,
    output logic               hnd_return,
    output logic [LVL_W-1:0]   run_prio
);
    localparam int IDLE_LVL = 1 << PRIO_W;
    localparam int CNT_W    = $clog2(ENTRY_CYCLES);
    localparam int SDW      = $clog2(STACK_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYCLES - 1);

    ctrl_state_e            state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [IDW-1:0]         sel_id_q, sel_id_d;
    logic [PRIO_W-1:0]      sel_prio_q, sel_prio_d;
    logic [NUM_SRC-1:0]     pend_q;
    logic [NUM_SRC-1:0]     clr_mask;

    logic                   start_d, chain_d, ret_d;
    logic [IDW-1:0]         hid_d;
    logic                   start_q, chain_q, ret_q;
    logic [IDW-1:0]         hid_q;

    logic [NUM_SRC-1:0]        en;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      best_valid;
    logic [IDW-1:0]            best_id;
    logic [PRIO_W-1:0]         best_prio;
    logic [LVL_W-1:0]          best_lvl;
    logic [LVL_W-1:0]          top_lvl, below_lvl;
    logic [SDW-1:0]            stk_depth;
    stk_op_e                   stk_op;
    logic [LVL_W-1:0]          stk_lvl;

    logic                      offer;
    logic                      late_win;
    logic [IDW-1:0]            cand_id;
    logic [PRIO_W-1:0]         cand_prio;

    irq_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .AW      (REG_AW),
        .DW      (REG_DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .pend_in  (pend_q),
        .en_out   (en),
        .prio_out (prio_flat)
    );

    irq_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .req        (pend_q & en),
        .prio       (prio_flat),
        .best_valid (best_valid),
        .best_id    (best_id),
        .best_prio  (best_prio)
    );

    irq_level_stack #(
        .DEPTH    (STACK_DEPTH),
        .LVL_W    (LVL_W),
        .IDLE_LVL (IDLE_LVL)
    ) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (stk_op),
        .lvl_in (stk_lvl),
        .top    (top_lvl),
        .below  (below_lvl),
        .depth  (stk_depth)
    );

    assign best_lvl  = {1'b0, best_prio};
    assign offer     = (state_q != ST_ENTRY) && best_valid && (best_lvl < top_lvl);
    assign late_win  = best_valid && (best_prio < sel_prio_q);
    assign cand_id   = late_win ? best_id   : sel_id_q;
    assign cand_prio = late_win ? best_prio : sel_prio_q;

    // Next-state and datapath decisions.
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        sel_id_d   = sel_id_q;
        sel_prio_d = sel_prio_q;
        clr_mask   = '0;
        stk_op     = STK_HOLD;
        stk_lvl    = best_lvl;
        start_d    = 1'b0;
        chain_d    = 1'b0;
        ret_d      = 1'b0;
        hid_d      = hid_q;
        unique case (state_q)
            ST_IDLE: begin
                if (offer && svc_take) begin
                    state_d    = ST_ENTRY;
                    cnt_d      = '0;
                    sel_id_d   = best_id;
                    sel_prio_d = best_prio;
                end
            end
            ST_ENTRY: begin
                if (cnt_q == CNT_LAST) begin
                    stk_op            = STK_PUSH;
                    stk_lvl           = {1'b0, cand_prio};
                    clr_mask[cand_id] = 1'b1;
                    start_d           = 1'b1;
                    hid_d             = cand_id;
                    state_d           = ST_RUN;
                end else begin
                    cnt_d      = cnt_q + CNT_W'(1);
                    sel_id_d   = cand_id;
                    sel_prio_d = cand_prio;
                end
            end
            ST_RUN: begin
                if (hnd_end) begin
                    if (best_valid && best_lvl < below_lvl) begin
                        stk_op            = STK_SWAP;
                        stk_lvl           = best_lvl;
                        clr_mask[best_id] = 1'b1;
                        start_d           = 1'b1;
                        chain_d           = 1'b1;
                        hid_d             = best_id;
                    end else begin
                        stk_op = STK_POP;
                        ret_d  = 1'b1;
                        if (stk_depth == SDW'(1)) state_d = ST_IDLE;
                    end
                end else if (offer && svc_take) begin
                    state_d    = ST_ENTRY;
                    cnt_d      = '0;
                    sel_id_d   = best_id;
                    sel_prio_d = best_prio;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            sel_id_q   <= '0;
            sel_prio_q <= '0;
            pend_q     <= '0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            sel_id_q   <= sel_id_d;
            sel_prio_q <= sel_prio_d;
            pend_q     <= (pend_q & ~clr_mask) | irq_in;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            chain_q <= 1'b0;
            ret_q   <= 1'b0;
            hid_q   <= '0;
        end else begin
            start_q <= start_d;
            chain_q <= chain_d;
            ret_q   <= ret_d;
            hid_q   <= hid_d;
        end
    end

    assign svc_valid   = offer;
    assign svc_id      = best_id;
    assign svc_preempt = offer && (stk_depth != '0);
    assign hnd_start   = start_q;
    assign hnd_chain   = chain_q;
    assign hnd_return  = ret_q;
    assign hnd_id      = hid_q;
    assign run_prio    = top_lvl;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_SRC     = 16,
    parameter int PRIO_W      = 3,
    parameter int STACK_DEPTH = 8,
    localparam int IDW        = $clog2(NUM_SRC),
    localparam int LVL_W      = PRIO_W + 1,
    localparam int SDW        = $clog2(STACK_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [NUM_SRC-1:0] pend,
    input logic               svc_valid,
    input logic               svc_take,
    input logic               hnd_start,
    input logic               hnd_chain,
    input logic               hnd_return,
    input logic [IDW-1:0]     hnd_id,
    input logic [LVL_W-1:0]   run_prio,
    input logic [SDW-1:0]     depth,
    input logic               in_entry,
    input logic [PRIO_W-1:0]  sel_prio
);
    logic [NUM_SRC-1:0] irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    assert_take_closes_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && svc_take) |=> !svc_valid);

    assert_late_only_upgrades_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_entry && $past(in_entry)) |-> (sel_prio <= $past(sel_prio)));

    assert_start_clears_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |-> (!pend[hnd_id] || irq_q[hnd_id]));

    assert_stack_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (depth <= SDW'(STACK_DEPTH)) && (run_prio <= LVL_W'(1 << PRIO_W)));

    assert_chain_keeps_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hnd_start && hnd_chain) |-> (depth == $past(depth)));

    assert_return_lowers_urgency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_return |-> (run_prio > $past(run_prio)));

    assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hnd_start && hnd_return));

    assert_no_return_from_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_return |-> !$past(in_entry));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC     (NUM_SRC),
    .PRIO_W      (PRIO_W),
    .STACK_DEPTH (STACK_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .pend       (pend_q),
    .svc_valid  (svc_valid),
    .svc_take   (svc_take),
    .hnd_start  (hnd_start),
    .hnd_chain  (hnd_chain),
    .hnd_return (hnd_return),
    .hnd_id     (hnd_id),
    .run_prio   (run_prio),
    .depth      (stk_depth),
    .in_entry   (state_q == irq_prio_pkg::ST_ENTRY),
    .sel_prio   (sel_prio_q)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        svc_valid;
    logic [3:0]  svc_id;
    logic        svc_preempt;
    logic        svc_take = 1'b0;
    logic        hnd_end = 1'b0;
    logic        hnd_start;
    logic [3:0]  hnd_id;
    logic        hnd_chain;
    logic        hnd_return;
    logic [3:0]  run_prio;

    int vectors = 0;
    int fails = 0;

    int          mprio [16];
    int          mstack [8];
    int          mdepth = 0;
    logic [15:0] men = '0;
    logic [15:0] mpend = '0;

    always #10 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .svc_valid   (svc_valid),
        .svc_id      (svc_id),
        .svc_preempt (svc_preempt),
        .svc_take    (svc_take),
        .hnd_end     (hnd_end),
        .hnd_start   (hnd_start),
        .hnd_id      (hnd_id),
        .hnd_chain   (hnd_chain),
        .hnd_return  (hnd_return),
        .run_prio    (run_prio)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic put_prio_regs();
        for (int r = 0; r < 4; r++) begin
            logic [31:0] d;
            d = '0;
            for (int j = 0; j < 4; j++) d |= 32'(mprio[4*r+j] & 7) << (8*j + 5);
            wr(r + 1, d);
        end
    endtask

    task automatic set_en(input logic [15:0] m);
        men = m;
        wr(0, {16'h0, m});
    endtask

    task automatic pulse_irq(input logic [15:0] m);
        @(negedge clk) irq_in = m;
        @(negedge clk) irq_in = '0;
        mpend |= m;
    endtask

    function automatic int best(input logic [15:0] m);
        int bi;
        bi = -1;
        for (int s = 0; s < 16; s++)
            if (m[s] && (bi < 0 || mprio[s] < mprio[bi])) bi = s;
        return bi;
    endfunction

    function automatic int mtop();
        return (mdepth == 0) ? 8 : mstack[mdepth-1];
    endfunction

    // Offer check, take, and entry timing (R3, R4, R5, R8, R11 when poked).
    task automatic start_entry(input int e, input bit pre, input bit poke);
        @(negedge clk);
        chk("R4 svc_valid", svc_valid, 1);
        chk("R3 svc_id", svc_id, e);
        chk("R4 svc_preempt", svc_preempt, pre);
        svc_take = 1'b1;
        @(negedge clk);
        svc_take = 1'b0;
        for (int c = 1; c <= 7; c++) begin
            @(negedge clk);
            hnd_end = poke && (c == 2);
        end
        hnd_end = 1'b0;
        chk("R5 no early start", hnd_start, 0);
        @(negedge clk);
        chk("R5 hnd_start", hnd_start, 1);
        chk("R5 hnd_id", hnd_id, e);
        chk("R5 hnd_chain", hnd_chain, 0);
        mstack[mdepth] = mprio[e];
        mdepth++;
        mpend[e] = 1'b0;
        chk("R8 run_prio after push", run_prio, mtop());
    endtask

    // Handler end, outcome from the bench model (R9, R10).
    task automatic end_check();
        int below, nb;
        below = (mdepth >= 2) ? mstack[mdepth-2] : 8;
        nb = best(mpend & men);
        @(negedge clk) hnd_end = 1'b1;
        @(negedge clk) hnd_end = 1'b0;
        if (nb >= 0 && mprio[nb] < below) begin
            mstack[mdepth-1] = mprio[nb];
            mpend[nb] = 1'b0;
            chk("R9 chained start", hnd_start, 1);
            chk("R9 chain flag", hnd_chain, 1);
            chk("R9 chained id", hnd_id, nb);
            chk("R9 run_prio", run_prio, mtop());
        end else begin
            mdepth--;
            chk("R10 return pulse", hnd_return, 1);
            chk("R10 no start", hnd_start, 0);
            chk("R10 run_prio", run_prio, mtop());
        end
    endtask

    task automatic drain();
        int e;
        e = best(mpend & men);
        if (e < 0) begin
            @(negedge clk);
            chk("R2 no offer", svc_valid, 0);
        end else begin
            start_entry(e, 1'b0, 1'b0);
            while (mdepth > 0) end_check();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int s = 0; s < 16; s++) mprio[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        @(negedge clk);
        chk("R12 run_prio", run_prio, 8);
        chk("R12 svc_valid", svc_valid, 0);
        chk("R12 hnd_start", hnd_start, 0);
        chk("R12 hnd_return", hnd_return, 0);
        rd(0, d); chk("R12 enables", d, 0);
        rd(2, d); chk("R12 priorities", d, 0);

        // R1 register layout and ignored bits
        wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R1 enable readback", d, 32'h0000_FFFF);
        wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R1 prio field mask", d, 32'hE0E0_E0E0);
        wr(3, 32'h4060_A0C0); rd(3, d); chk("R1 prio fields", d, 32'h4060_A0C0);
        wr(5, 32'hFFFF_FFFF); rd(5, d); chk("R1 pending write ignored", d, 0);
        wr(6, 32'hFFFF_FFFF); rd(6, d); chk("R1 unused address", d, 0);
        rd(7, d); chk("R1 unused address 7", d, 0);
        men = 16'hFFFF;

        // R11 end strobe while idle
        @(negedge clk) hnd_end = 1'b1;
        @(negedge clk) hnd_end = 1'b0;
        chk("R11 idle end no return", hnd_return, 0);
        chk("R11 idle run_prio", run_prio, 8);

        // R2 R3 R7 R9 sweep of priorities, enables and request patterns
        for (int it = 0; it < 24; it++) begin
            logic [15:0] msk, en_m;
            for (int s = 0; s < 16; s++) mprio[s] = (s * (it + 3) + it * 5) % 8;
            put_prio_regs();
            en_m = (it % 3 == 0) ? 16'hFFFF : ~(16'h0101 << (it % 8));
            set_en(en_m);
            msk = 16'((it * 40503 + 12345) ^ (it << 7));
            pulse_irq(msk);
            drain();
            rd(5, d); chk("R2 R7 pending after drain", d, {16'h0, mpend});
            set_en(16'hFFFF);
            drain();
            rd(5, d); chk("R7 pending empty", d, 0);
        end

        // R4 preemption: equal and lower urgency wait, strictly higher preempts
        for (int s = 0; s < 16; s++) mprio[s] = 7;
        mprio[3] = 5; mprio[9] = 5; mprio[12] = 6; mprio[7] = 2;
        put_prio_regs();
        pulse_irq(16'h0008);
        start_entry(3, 1'b0, 1'b0);
        pulse_irq(16'h1200);
        @(negedge clk);
        chk("R4 equal or lower not offered", svc_valid, 0);
        pulse_irq(16'h0080);
        start_entry(7, 1'b1, 1'b1);
        chk("R11 end during entry ignored", run_prio, 2);
        while (mdepth > 0) end_check();

        // R8 eight nested levels
        for (int k = 0; k < 8; k++) mprio[8 + k] = 7 - k;
        put_prio_regs();
        for (int k = 0; k < 8; k++) begin
            pulse_irq(16'(1 << (8 + k)));
            start_entry(8 + k, k > 0, 1'b0);
        end
        chk("R8 deepest run_prio", run_prio, 0);
        while (mdepth > 0) end_check();
        chk("R8 idle again", run_prio, 8);

        // R6 late arrival during entry
        for (int s = 0; s < 16; s++) mprio[s] = 7;
        mprio[5] = 4; mprio[2] = 4; mprio[11] = 1;
        put_prio_regs();
        pulse_irq(16'h0020);
        @(negedge clk);
        chk("R6 first offer", svc_id, 5);
        svc_take = 1'b1;
        @(negedge clk);
        svc_take = 1'b0;
        repeat (2) @(negedge clk);
        irq_in = 16'h0004;
        @(negedge clk) irq_in = 16'h0800;
        @(negedge clk) irq_in = '0;
        mpend |= 16'h0824;
        repeat (3) @(negedge clk);
        chk("R6 window not restarted", hnd_start, 0);
        @(negedge clk);
        chk("R6 start on time", hnd_start, 1);
        chk("R6 replaced by more urgent", hnd_id, 11);
        chk("R6 run_prio", run_prio, 1);
        mstack[0] = 1; mdepth = 1; mpend[11] = 1'b0;
        rd(5, d); chk("R6 R7 pending kept", d, 32'h0024);
        while (mdepth > 0) end_check();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule